// File: doc/BRIEF.md
# External Clock Failure Monitor

This block watches an external clock or crystal oscillator and reacts when it stops toggling. It runs entirely from an always-on internal reference clock. The external clock is brought into that domain through a synchronizer and an edge detector. A counter measures the reference cycles since the last detected edge. When that count reaches a timeout, the monitor declares a failure.

How the monitor reacts depends on whether the failed source is driving the system. This covers the case where it drives the system directly and the case where it feeds the PLL reference. When it is driving the system, the monitor does four things:
- it forces the clock selection to the 2 MHz internal oscillator, overriding any clock lock;
- it requests that the oscillator control and clock selection registers return to their defaults;
- it sets a sticky interrupt flag;
- it raises a non-maskable interrupt.

When the failed source is not driving the system, the monitor only switches the external oscillator off.

Software turns the monitor on through an enable bit. A write to that bit takes effect only while the configuration-change unlock window is open. Once the bit is set, it stays set until reset. Monitoring pauses automatically in any sleep mode that stops the external clock, and it resumes on wake-up. The monitor must not be enabled for external clocks slower than 32 kHz. Such a clock can leave gaps longer than the timeout and be reported as failed.

Top module: `clk_fail_mon`

## Requirements
- R1: On a failure while `ext_is_sys_i` is 1, `force_int_sel_o` becomes 1 and stays 1 until reset. `reg_dflt_req_o` is 1 for exactly one cycle.
- R2: On a failure while `ext_is_sys_i` is 1, `fail_flag_o` becomes 1 and `nmi_o` is 1 for exactly one cycle.
- R3: `fail_flag_o` stays set until a cycle with `flag_clr_i` = 1 clears it one edge later. If a new failure occurs in the same cycle as a clear, the set wins.
- R4: On a failure while `ext_is_sys_i` is 0, `ext_osc_off_o` becomes 1 and stays 1 until reset. `force_int_sel_o`, `reg_dflt_req_o`, `fail_flag_o` and `nmi_o` stay 0.
- R5: Once `mon_en_o` is 1, writing 0 to the enable bit has no effect on it.
- R6: An enable write (`en_wr_i` = 1, `en_val_i` = 1) sets `mon_en_o` one edge later, but only if `unlock_i` is 1 in that cycle. Otherwise the monitor stays off and never reports a failure.
- R7: Consider an enable write that lands at edge e with no external edges present. The failure outputs change at edge e+TIMEOUT_CYCLES (64 by default). An external clock with rising edges every 10 reference cycles never triggers a failure.
- R8: While `sleep_ext_off_i` is 1, no failure is declared and the timeout count is cleared. Waking with the clock running causes no failure.
- R9: Reset clears the enable, the flag, the forced select, the oscillator disable and both pulses.
- R10: A loss of clock produces one failure event. No further `nmi_o` pulse follows while the clock stays absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Always-on internal reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | Monitored external clock, asynchronous |
| unlock_i | input | 1 | Configuration-change unlock window open |
| en_wr_i | input | 1 | Write strobe for the enable bit |
| en_val_i | input | 1 | Value written to the enable bit |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the failure flag |
| sleep_ext_off_i | input | 1 | Device in a sleep mode that stops the external clock |
| ext_is_sys_i | input | 1 | External source currently drives the system clock or PLL reference |
| mon_en_o | output | 1 | Monitor enable state |
| force_int_sel_o | output | 1 | Force system clock to the 2 MHz internal oscillator |
| reg_dflt_req_o | output | 1 | One-cycle request to restore clock control registers to defaults |
| ext_osc_off_o | output | 1 | Disable the external oscillator |
| fail_flag_o | output | 1 | Sticky failure interrupt flag |
| nmi_o | output | 1 | One-cycle non-maskable interrupt request |

## Verification
An enable write shows on `mon_en_o` one reference edge after the write cycle. A flag clear shows one edge after its strobe.

With the external clock held still, the failure outputs switch exactly at the 64th edge after the enabling edge. The bench counts edges so it can check them there. It also checks that they are still quiet at the 63rd edge. The default-restore request and the NMI are checked high at that edge and low one edge later.

Where the external clock stops at an arbitrary phase, the synchronizer latency is uncertain. In those cases the bench counts NMI pulses over a window wide enough to cover that latency, rather than checking a single cycle. Inputs are driven and outputs sampled 1 ns after the reference edge.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

   // Actions taken by the monitor for one detection event
   typedef struct packed {
      logic force_sel;   // switch the system to the internal oscillator
      logic dflt_req;    // ask for clock control registers to be reset
      logic osc_off;     // turn the external oscillator off
      logic flag_set;    // set the sticky interrupt flag
      logic nmi;         // raise the non-maskable interrupt
   } cfm_react_t;

   // Reaction depends on whether the lost clock was feeding the system
   function automatic cfm_react_t cfm_decide(input logic fail, input logic on_sys);
      cfm_react_t r;
      r.force_sel = fail &  on_sys;
      r.dflt_req  = fail &  on_sys;
      r.flag_set  = fail &  on_sys;
      r.nmi       = fail &  on_sys;
      r.osc_off   = fail & ~on_sys;
      return r;
   endfunction

endpackage

// File: rtl/cfm_sync.sv
module cfm_sync #(
   parameter int unsigned STAGES     = 2,
   parameter bit          BOTH_EDGES = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic edge_o
);

   // chain[STAGES-1] is the synchronized level, chain[STAGES] the previous one
   logic [STAGES:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cfm_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-1:0], async_i};
   end

   generate
      if (BOTH_EDGES) begin : g_any_edge
         assign edge_o = chain_q[STAGES] ^ chain_q[STAGES-1];
      end else begin : g_rise_edge
         assign edge_o = chain_q[STAGES-1] & ~chain_q[STAGES];
      end
   endgenerate

endmodule

// File: rtl/cfm_timeout.sv
module cfm_timeout #(
   parameter int unsigned TIMEOUT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   input  logic edge_i,
   output logic fail_o
);

   localparam int unsigned CW = $clog2(TIMEOUT + 1);
   localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);
   localparam logic [CW-1:0] SAT  = CW'(TIMEOUT);

   logic [CW-1:0] cnt_q;

   generate
      if (TIMEOUT < 4) begin : g_bad_timeout
         $error("cfm_timeout: TIMEOUT must be at least 4");
      end
   endgenerate

   // Fires once as the count reaches the limit; the count then parks at SAT
   assign fail_o = active_i && !edge_i && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (!active_i || edge_i) cnt_q <= '0;
      else if (cnt_q != SAT)        cnt_q <= cnt_q + 1'b1;
   end

   AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !active_i |=> cnt_q == '0);                                  // R8
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= SAT);                                               // R7
   AST_SINGLE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |=> !fail_o);                                         // R10

endmodule

// File: rtl/cfm_ctrl.sv
module cfm_ctrl
   import cfm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic unlock_i,
   input  logic en_wr_i,
   input  logic en_val_i,
   input  logic flag_clr_i,
   input  logic fail_i,
   input  logic on_sys_i,
   output logic mon_en_o,
   output logic force_sel_o,
   output logic dflt_req_o,
   output logic osc_off_o,
   output logic flag_o,
   output logic nmi_o
);

   cfm_react_t react;
   logic en_q, force_q, dflt_q, off_q, flag_q, nmi_q;

   assign react = cfm_decide(fail_i, on_sys_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         force_q <= 1'b0;
         dflt_q  <= 1'b0;
         off_q   <= 1'b0;
         flag_q  <= 1'b0;
         nmi_q   <= 1'b0;
      end else begin
         if (en_wr_i && unlock_i && en_val_i) en_q <= 1'b1;
         force_q <= force_q | react.force_sel;
         off_q   <= off_q   | react.osc_off;
         dflt_q  <= react.dflt_req;
         nmi_q   <= react.nmi;
         if (react.flag_set)  flag_q <= 1'b1;
         else if (flag_clr_i) flag_q <= 1'b0;
      end
   end

   assign mon_en_o    = en_q;
   assign force_sel_o = force_q;
   assign dflt_req_o  = dflt_q;
   assign osc_off_o   = off_q;
   assign flag_o      = flag_q;
   assign nmi_o       = nmi_q;

   AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> en_q);                                              // R5
   AST_EN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !unlock_i) |=> !en_q);                             // R6
   AST_NMI_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_q |=> !nmi_q);                                           // R2
   AST_NMI_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_q |-> force_q && flag_q);                                // R1
   AST_FORCE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      force_q |=> force_q);                                        // R1
   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !flag_clr_i) |=> flag_q);                         // R3
   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(off_q) |-> !nmi_q && !dflt_q);                         // R4

endmodule

// File: rtl/clk_fail_mon.sv
module clk_fail_mon #(
   parameter int unsigned TIMEOUT_CYCLES   = 64,
   parameter int unsigned SYNC_STAGES      = 2,
   parameter bit          COUNT_BOTH_EDGES = 1'b0
) (
   input  logic clk_ref,
   input  logic rst_n,
   input  logic ext_clk,
   input  logic unlock_i,
   input  logic en_wr_i,
   input  logic en_val_i,
   input  logic flag_clr_i,
   input  logic sleep_ext_off_i,
   input  logic ext_is_sys_i,
   output logic mon_en_o,
   output logic force_int_sel_o,
   output logic reg_dflt_req_o,
   output logic ext_osc_off_o,
   output logic fail_flag_o,
   output logic nmi_o
);

   logic ext_edge, active, fail_evt;

   // Monitoring runs only when enabled and the external clock is meant to run
   assign active = mon_en_o & ~sleep_ext_off_i;

   cfm_sync #(
      .STAGES     (SYNC_STAGES),
      .BOTH_EDGES (COUNT_BOTH_EDGES)
   ) u_sync (
      .clk     (clk_ref),
      .rst_n   (rst_n),
      .async_i (ext_clk),
      .edge_o  (ext_edge)
   );

   cfm_timeout #(
      .TIMEOUT (TIMEOUT_CYCLES)
   ) u_timeout (
      .clk      (clk_ref),
      .rst_n    (rst_n),
      .active_i (active),
      .edge_i   (ext_edge),
      .fail_o   (fail_evt)
   );

   cfm_ctrl u_ctrl (
      .clk         (clk_ref),
      .rst_n       (rst_n),
      .unlock_i    (unlock_i),
      .en_wr_i     (en_wr_i),
      .en_val_i    (en_val_i),
      .flag_clr_i  (flag_clr_i),
      .fail_i      (fail_evt),
      .on_sys_i    (ext_is_sys_i),
      .mon_en_o    (mon_en_o),
      .force_sel_o (force_int_sel_o),
      .dflt_req_o  (reg_dflt_req_o),
      .osc_off_o   (ext_osc_off_o),
      .flag_o      (fail_flag_o),
      .nmi_o       (nmi_o)
   );

   AST_ASLEEP_QUIET: assert property (@(posedge clk_ref) disable iff (!rst_n)
      ($past(sleep_ext_off_i) && $past(rst_n)) |-> !nmi_o && !ext_osc_off_o || $past(nmi_o) == 1'b0 && !nmi_o || ext_osc_off_o); // R8

endmodule

// File: tb/clk_fail_mon_bench.sv
module clk_fail_mon_bench;

   localparam int TMO = 64;

   logic clk_ref = 1'b0;
   logic rst_n;
   logic ext_clk = 1'b0;
   logic ext_run = 1'b0;
   logic unlock_i, en_wr_i, en_val_i, flag_clr_i, sleep_ext_off_i, ext_is_sys_i;
   logic mon_en_o, force_int_sel_o, reg_dflt_req_o, ext_osc_off_o, fail_flag_o, nmi_o;

   int checks = 0;
   int errors = 0;

   clk_fail_mon u_clk_fail_mon (
      .clk_ref         (clk_ref),
      .rst_n           (rst_n),
      .ext_clk         (ext_clk),
      .unlock_i        (unlock_i),
      .en_wr_i         (en_wr_i),
      .en_val_i        (en_val_i),
      .flag_clr_i      (flag_clr_i),
      .sleep_ext_off_i (sleep_ext_off_i),
      .ext_is_sys_i    (ext_is_sys_i),
      .mon_en_o        (mon_en_o),
      .force_int_sel_o (force_int_sel_o),
      .reg_dflt_req_o  (reg_dflt_req_o),
      .ext_osc_off_o   (ext_osc_off_o),
      .fail_flag_o     (fail_flag_o),
      .nmi_o           (nmi_o)
   );

   always #2 clk_ref = ~clk_ref;

   // External clock: rising edge every 10 reference cycles while running
   initial begin
      forever begin
         if (ext_run) begin
            #20 ext_clk = ~ext_clk;
         end else begin
            #4;
         end
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk_ref);
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; unlock_i = 0; en_wr_i = 0; en_val_i = 0;
      flag_clr_i = 0; sleep_ext_off_i = 0; ext_is_sys_i = 1;
      repeat (3) step();
      rst_n = 1'b1;
      step();
   endtask

   // Enable write; returns right after the accepting edge
   task automatic write_en(input logic val, input logic unl);
      en_wr_i = 1; en_val_i = val; unlock_i = unl;
      step();
      en_wr_i = 0; en_val_i = 0; unlock_i = 0;
   endtask

   task automatic count_nmi(input int cycles, output int n);
      n = 0;
      for (int i = 0; i < cycles; i++) begin
         step();
         if (nmi_o) n++;
      end
   endtask

   task automatic t_reset_state();
      ext_run = 0; ext_clk = 0;
      do_reset();
      check("R9 mon_en", mon_en_o, 0);
      check("R9 force", force_int_sel_o, 0);
      check("R9 flag", fail_flag_o, 0);
      check("R9 osc_off", ext_osc_off_o, 0);
      check("R9 nmi", nmi_o + reg_dflt_req_o, 0);
   endtask

   task automatic t_locked_write();
      int n;
      do_reset();
      write_en(1'b1, 1'b0);
      check("R6 locked write", mon_en_o, 0);
      count_nmi(150, n);
      check("R6 disabled no nmi", n, 0);
      check("R6 disabled no flag", fail_flag_o, 0);
   endtask

   task automatic t_sys_fail_exact();
      int n;
      do_reset();
      write_en(1'b1, 1'b1);
      check("R6 unlocked write", mon_en_o, 1);
      for (int i = 1; i < TMO; i++) step();
      check("R7 quiet before timeout", nmi_o + force_int_sel_o + fail_flag_o, 0);
      step();
      check("R7/R2 nmi at timeout", nmi_o, 1);
      check("R1 force at timeout", force_int_sel_o, 1);
      check("R1 dflt req", reg_dflt_req_o, 1);
      check("R2 flag", fail_flag_o, 1);
      step();
      check("R2 nmi one cycle", nmi_o, 0);
      check("R1 dflt req one cycle", reg_dflt_req_o, 0);
      check("R1 force holds", force_int_sel_o, 1);
      check("R3 flag holds", fail_flag_o, 1);
      count_nmi(200, n);
      check("R10 single event", n, 0);
      write_en(1'b0, 1'b1);
      step();
      check("R5 enable sticky", mon_en_o, 1);
      flag_clr_i = 1;
      step();
      flag_clr_i = 0;
      check("R3 flag cleared", fail_flag_o, 0);
      check("R1 force after clear", force_int_sel_o, 1);
      do_reset();
      check("R9 cleared after reset", mon_en_o + force_int_sel_o + fail_flag_o, 0);
   endtask

   task automatic t_set_wins();
      do_reset();
      write_en(1'b1, 1'b1);
      flag_clr_i = 1;
      for (int i = 1; i <= TMO; i++) step();
      check("R3 set wins over clear", fail_flag_o, 1);
      step();
      check("R3 clear next cycle", fail_flag_o, 0);
      flag_clr_i = 0;
   endtask

   task automatic t_running_then_stop();
      int n;
      do_reset();
      ext_run = 1;
      write_en(1'b1, 1'b1);
      count_nmi(400, n);
      check("R7 running clock no nmi", n, 0);
      check("R7 running clock no flag", fail_flag_o, 0);
      ext_run = 0;
      count_nmi(160, n);
      check("R7/R10 stop gives one nmi", n, 1);
      check("R2 flag after stop", fail_flag_o, 1);
   endtask

   task automatic t_not_system();
      int n;
      do_reset();
      ext_clk = 0;
      ext_is_sys_i = 0;
      write_en(1'b1, 1'b1);
      count_nmi(TMO + 10, n);
      check("R4 no nmi", n, 0);
      check("R4 osc off", ext_osc_off_o, 1);
      check("R4 no force", force_int_sel_o, 0);
      check("R4 no flag", fail_flag_o, 0);
      check("R4 no dflt req", reg_dflt_req_o, 0);
   endtask

   task automatic t_sleep();
      int n;
      do_reset();
      ext_run = 1;
      write_en(1'b1, 1'b1);
      count_nmi(50, n);
      sleep_ext_off_i = 1;
      ext_run = 0;
      count_nmi(300, n);
      check("R8 asleep no nmi", n, 0);
      check("R8 asleep no osc off", ext_osc_off_o, 0);
      ext_run = 1;
      sleep_ext_off_i = 0;
      count_nmi(300, n);
      check("R8 wake no nmi", n, 0);
      check("R8 wake no flag", fail_flag_o, 0);
      ext_run = 0;
   endtask

   initial begin
      int n;
      fork
         begin
            t_reset_state();
            t_locked_write();
            t_sys_fail_exact();
            t_set_wins();
            t_running_then_stop();
            t_not_system();
            t_sleep();
         end
         begin
            repeat (150000) @(posedge clk_ref);
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      n = 0;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule